// File: doc/BRIEF.md
# Dual-Mode Timer with Capture

The block holds two 16-bit down-counters, each advanced by its own clock-enable strobe. Both run in one of two modes. In dual-timer mode each counter is an auto-reload timer with its own reload register. In capture mode, counter 1 keeps its auto-reload behaviour. Counter 2 becomes a free-running time base: on a chosen edge of the capture pin, its value is latched into the B register.

Counter 1 can drive a square-wave output pin that flips on every one of its underflows. This gives a 50% duty waveform with no software involvement. Three pending flags (A, B, D) are combined with per-flag enables onto two interrupt lines. Software clears a flag by writing 1 to its bit.

All state is reached through a single-cycle register port. Writes take effect at the clock edge, and reads are combinational from the address.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, every counter, reload/capture register, the control register and all pending flags read 0, and `tog_out`, `irq1` and `irq2` are low.
- R2: Register map: address 0 is counter 1, 1 is reload A, 2 is counter 2, 3 is register B, 4 is control, 5 is status. A write of a counter loads it at that edge and takes priority over its tick.
- R3: Counter 1 drops by one per `tick1`. A tick while it holds 0 is an underflow: it reloads from reload A and sets flag A (status bit 0). This holds in both modes.
- R4: Writing control copies control bit 2 onto `tog_out`. While control bit 1 is set, `tog_out` inverts on each counter 1 underflow; while it is clear, the pin holds its value.
- R5: `irq1` is high exactly when flag A is set and control bit 5 is 1.
- R6: In dual-timer mode (control bit 0 = 0), counter 2 drops per `tick2`. A tick at 0 reloads it from register B and sets flag D (status bit 2). The capture pin has no effect in this mode.
- R7: In capture mode (control bit 0 = 1), a qualifying edge on `cap_in` copies counter 2 into register B and sets flag B (status bit 1). The copy happens three clock edges after the pin changes, through a two-flop synchronizer.
- R8: Control bit 3 selects the edge: 0 rising, 1 falling. An edge of the other polarity causes no capture and sets no flag.
- R9: With control bit 4 set in capture mode, counter 2 is forced to 0xFFFF at each capture and counts down from there. With the bit clear, it keeps counting.
- R10: In capture mode, a `tick2` while counter 2 holds 0 wraps it to 0xFFFF and sets flag D.
- R11: `irq2` is high when flag B is set with control bit 6 = 1, or when flag D is set with control bit 7 = 1.
- R12: Writing status clears each flag whose data bit is 1. A set event in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tick1 | input | 1 | Count enable for counter 1 |
| tick2 | input | 1 | Count enable for counter 2 |
| cap_in | input | 1 | Asynchronous capture input |
| tog_out | output | 1 | Square-wave output driven by counter 1 |
| irq1 | output | 1 | Interrupt from flag A |
| irq2 | output | 1 | Interrupt from flags B and D |

## Verification
A wrong counter value shows up on `bus_rdata` within the same cycle it is read. It also changes the period of `tog_out` and `irq1`, so a bad reload is visible one underflow later. A synchronizer or edge-detector fault shows three edges after the pin moves, as a wrong register B value or a flag B that is missing or spurious. A broken flag clear or set-priority rule shows on `irq1`/`irq2` in the cycle after the write.

// File: rtl/dual_mode_timer.sv
module dual_mode_timer #(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          tick1,
  input  logic          tick2,
  input  logic          cap_in,
  output logic          tog_out,
  output logic          irq1,
  output logic          irq2
);
  localparam logic [AW-1:0] A_CNT1 = AW'(0);
  localparam logic [AW-1:0] A_RELA = AW'(1);
  localparam logic [AW-1:0] A_CNT2 = AW'(2);
  localparam logic [AW-1:0] A_REGB = AW'(3);
  localparam logic [AW-1:0] A_CTRL = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);
  localparam int CTLW = 8;

  logic [CW-1:0] cnt1, rela, cnt2, regb;
  logic [CTLW-1:0] ctrl;
  logic pend_a, pend_b, pend_d;
  logic sy1, sy2, sy3;

  wire mode_cap  = ctrl[0];
  wire tog_en    = ctrl[1];
  wire tog_init  = ctrl[2];
  wire fall_sel  = ctrl[3];
  wire preset_en = ctrl[4];
  wire ien_a     = ctrl[5];
  wire ien_b     = ctrl[6];
  wire ien_d     = ctrl[7];

  wire wr_cnt1 = bus_wr && bus_addr == A_CNT1;
  wire wr_rela = bus_wr && bus_addr == A_RELA;
  wire wr_cnt2 = bus_wr && bus_addr == A_CNT2;
  wire wr_regb = bus_wr && bus_addr == A_REGB;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire [2:0] clr = wr_stat ? bus_wdata[2:0] : 3'b000;

  wire cap_hit = mode_cap && (fall_sel ? (sy3 && !sy2) : (!sy3 && sy2));
  wire force_ff = cap_hit && preset_en;
  wire unf1 = tick1 && cnt1 == '0 && !wr_cnt1;
  wire unf2 = tick2 && cnt2 == '0 && !wr_cnt2 && !force_ff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sy1, sy2, sy3} <= 3'b000;
    else        {sy1, sy2, sy3} <= {cap_in, sy1, sy2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rela <= '0;
      ctrl <= '0;
    end else begin
      if (wr_rela) rela <= bus_wdata;
      if (wr_ctrl) ctrl <= bus_wdata[CTLW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt1 <= '0;
    else if (wr_cnt1)   cnt1 <= bus_wdata;
    else if (tick1)     cnt1 <= (cnt1 == '0) ? rela : cnt1 - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt2 <= '0;
    else if (force_ff)  cnt2 <= '1;
    else if (wr_cnt2)   cnt2 <= bus_wdata;
    else if (tick2)     cnt2 <= (cnt2 != '0) ? cnt2 - 1'b1 : (mode_cap ? '1 : regb);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         regb <= '0;
    else if (cap_hit)   regb <= cnt2;
    else if (wr_regb)   regb <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                tog_out <= 1'b0;
    else if (wr_ctrl)          tog_out <= bus_wdata[2];
    else if (unf1 && tog_en)   tog_out <= !tog_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
      pend_d <= 1'b0;
    end else begin
      pend_a <= unf1    || (pend_a && !clr[0]);
      pend_b <= cap_hit || (pend_b && !clr[1]);
      pend_d <= unf2    || (pend_d && !clr[2]);
    end

  assign irq1 = pend_a && ien_a;
  assign irq2 = (pend_b && ien_b) || (pend_d && ien_d);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT1:  bus_rdata = cnt1;
      A_RELA:  bus_rdata = rela;
      A_CNT2:  bus_rdata = cnt2;
      A_REGB:  bus_rdata = regb;
      A_CTRL:  bus_rdata = CW'(ctrl);
      A_STAT:  bus_rdata = CW'({pend_d, pend_b, pend_a});
      default: bus_rdata = '0;
    endcase
  end

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unf1 |=> (cnt1 == $past(rela) && pend_a));
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unf1 && tog_en && !wr_ctrl) |=> tog_out != $past(tog_out));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tog_en && !wr_ctrl) |=> $stable(tog_out));
  p_no_cap_dual_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_cap && !wr_regb) |=> $stable(regb));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> (regb == $past(cnt2) && pend_b));
  p_preset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_ff |=> cnt2 == '1);
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cap && unf2) |=> (cnt2 == '1 && pend_d));
  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[0] && !unf1) |=> !pend_a);
endmodule

// File: tb/dual_mode_timer_bench.sv
module dual_mode_timer_bench;
  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic tick1 = 0, tick2 = 0, cap_in = 0;
  logic tog_out, irq1, irq2;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {int kind; logic [2:0] a; logic [15:0] exp; string tag;} item_t;
  item_t q[$];

  always #4 clk = ~clk;

  dual_mode_timer u_dual_mode_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick1(tick1), .tick2(tick2),
    .cap_in(cap_in), .tog_out(tog_out), .irq1(irq1), .irq2(irq2));

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {15'd0, tog_out};
        2: act = {15'd0, irq1};
        default: act = {15'd0, irq2};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h", it.tag, it.kind, it.a, act, it.exp);
      end
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_wr = 0;
  endtask

  task automatic t1(int n);
    tick1 = 1; step(n); tick1 = 0;
  endtask

  task automatic t2(int n);
    tick2 = 1; step(n); tick2 = 0;
  endtask

  task automatic exp_reg(logic [2:0] a, logic [15:0] e, string tag);
    item_t it;
    bus_addr = a;
    it.kind = 0; it.a = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    step(1);
  endtask

  task automatic exp_pin(int k, logic v, string tag);
    item_t it;
    it.kind = k; it.a = '0; it.exp = {15'd0, v}; it.tag = tag;
    q.push_back(it);
    step(1);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    for (int a = 0; a < 6; a++) exp_reg(3'(a), 16'h0, "R1 reset reg");
    exp_pin(1, 0, "R1 tog");
    exp_pin(2, 0, "R1 irq1");
    exp_pin(3, 0, "R1 irq2");

    wr(1, 16'd3);
    wr(0, 16'd2);
    exp_reg(1, 16'd3, "R2 reload A readback");
    exp_reg(0, 16'd2, "R2 counter 1 readback");
    wr(4, 16'h0026);
    exp_pin(1, 1, "R4 init high");
    t1(1);
    exp_reg(0, 16'd1, "R3 decrement");
    t1(2);
    exp_reg(0, 16'd3, "R3 reload");
    exp_reg(5, 16'd1, "R3 flag A");
    exp_pin(1, 0, "R4 toggle");
    exp_pin(2, 1, "R5 irq1 on");
    t1(4);
    exp_reg(0, 16'd3, "R3 period");
    exp_pin(1, 1, "R4 toggle again");

    wr(5, 16'd1);
    exp_reg(5, 16'd0, "R12 clear");
    exp_pin(2, 0, "R5 irq1 off");
    t1(3);
    exp_reg(0, 16'd0, "R3 at zero");
    bus_wr = 1; bus_addr = 5; bus_wdata = 16'd1; tick1 = 1;
    step(1);
    bus_wr = 0; tick1 = 0;
    exp_reg(5, 16'd1, "R12 set wins");
    exp_reg(0, 16'd3, "R3 reload under clear");
    wr(5, 16'd1);

    wr(4, 16'h0004);
    t1(4);
    exp_reg(5, 16'd1, "R3 flag A no ien");
    exp_pin(2, 0, "R5 masked");
    exp_pin(1, 1, "R4 hold when disabled");
    wr(5, 16'd1);

    wr(4, 16'h0080);
    exp_pin(1, 0, "R4 ctrl write sets pin");
    wr(3, 16'd2);
    wr(2, 16'd0);
    t2(1);
    exp_reg(2, 16'd2, "R6 reload B");
    exp_reg(5, 16'd4, "R6 flag D");
    exp_pin(3, 1, "R11 irq2 from D");
    t2(2);
    exp_reg(2, 16'd0, "R6 decrement");
    cap_in = 1; step(5);
    exp_reg(3, 16'd2, "R6 cap ignored in dual");
    exp_reg(5, 16'd4, "R6 no flag B in dual");
    cap_in = 0; step(5);
    wr(5, 16'd7);

    wr(4, 16'h0041);
    wr(2, 16'd100);
    cap_in = 1;
    step(2);
    exp_reg(3, 16'd2, "R7 not before third edge");
    step(3);
    exp_reg(3, 16'd100, "R7 rising capture");
    exp_reg(5, 16'd2, "R7 flag B");
    exp_pin(3, 1, "R11 irq2 from B");
    exp_reg(2, 16'd100, "R9 no preset");
    wr(5, 16'd7);
    exp_pin(3, 0, "R11 irq2 cleared");

    wr(4, 16'h0059);
    wr(2, 16'd50);
    cap_in = 0; step(5);
    exp_reg(3, 16'd50, "R8 falling capture");
    exp_reg(5, 16'd2, "R8 flag B falling");
    exp_reg(2, 16'hFFFF, "R9 preset");
    t2(3);
    exp_reg(2, 16'hFFFC, "R9 count from preset");
    wr(5, 16'd7);
    cap_in = 1; step(5);
    exp_reg(5, 16'd0, "R8 rising ignored");
    exp_reg(3, 16'd50, "R8 B unchanged");

    wr(4, 16'h0081);
    wr(2, 16'd0);
    t2(1);
    exp_reg(2, 16'hFFFF, "R10 wrap");
    exp_reg(5, 16'd4, "R10 flag D");
    exp_pin(3, 1, "R11 irq2 D capture mode");
    wr(5, 16'd7);

    wr(0, 16'd0);
    t1(1);
    exp_reg(0, 16'd3, "R3 reload in capture mode");
    exp_reg(5, 16'd1, "R3 flag A capture mode");

    step(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule